// File: doc/BRIEF.md
# Execution Trace Record Serializer

This block takes a snapshot of one retired instruction, pulses of a capture strobe alongside the record fields, and hands the record out again as eight 18-bit items. Each read strobe pulls the next item, so a consumer that reads eight times in a row gets one whole record. All 32-bit quantities are split across items at uneven boundaries, most significant bit first. The item order and the bit placement are fixed.

The block holds at most two records: the one being read out, and a single pending record taken while the first is still in flight. When the eighth item of a record leaves, a one-cycle done flag rises and the pending record, if there is one, moves up for reading. Two choices are made inside the block before capture. The data word is the store data for a store and the result data otherwise. The address word is the data address for a load or store and the instruction word otherwise.

Top module: `trace_record_serializer`

## Requirements
- R1: After reset, item_o is zero, item_vld_o and rec_done_o are low, and no record is held.
- R2: Item 1 carries the 15-bit cycle count in bits 17:3 and the three most significant bits of the 15-bit status in bits 2:0.
- R3: Item 2 carries the remaining twelve status bits in bits 17:6, the destination register index in bits 5:1 and the write flag in bit 0.
- R4: Item 3 holds the following: exception kind in bits 17:13, exception-taken in bit 12, load flag in bit 11, store flag in bit 10, byte enables in bits 9:6, and data-word bits 31:26 in bits 5:0. The data word is st_data_i when the store flag is set and res_data_i otherwise.
- R5: Item 4 carries data-word bits 25:8. Item 5 carries data-word bits 7:0 in bits 17:10 and address-word bits 31:22 in bits 9:0. The address word is data_addr_i when the load or store flag is set and instr_i otherwise.
- R6: Item 6 carries address-word bits 21:4. Item 7 carries address-word bits 3:0 in bits 17:14 and program-counter bits 31:18 in bits 13:0. Item 8 carries program-counter bits 17:0.
- R7: A read strobe with a record held puts the next item on item_o with item_vld_o high in the following cycle. item_vld_o is low in every cycle not following a read, and item_o keeps its last value then.
- R8: A read strobe with no record held gives item_o zero and item_vld_o low in the following cycle.
- R9: rec_done_o is high for exactly the one cycle in which the eighth item is shown. The next read returns item 1 of the next record.
- R10: A capture while a record is being read is kept as pending and is read out, in full, right after the current record.
- R11: A capture while both the current and pending slots are full, and the cycle's read does not finish the current record, is dropped.
- R12: In a cycle with both strobes, the read is served first and the capture is placed afterwards. A capture alongside an eighth read is accepted even if the pending slot was full. A capture alongside a read with nothing held is accepted, while that read still returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Capture strobe for the record fields |
| cyc_cnt_i | input | 15 | Cycle count of the instruction |
| status_i | input | 15 | Status bits |
| dst_idx_i | input | 5 | Destination register index |
| dst_wr_i | input | 1 | Destination register written |
| exc_kind_i | input | 5 | Exception kind |
| exc_taken_i | input | 1 | Exception taken |
| is_load_i | input | 1 | Instruction is a load |
| is_store_i | input | 1 | Instruction is a store |
| byte_en_i | input | 4 | Store byte enables |
| st_data_i | input | 32 | Store write data |
| res_data_i | input | 32 | Destination register data |
| data_addr_i | input | 32 | Load/store data address |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Program counter |
| rd_i | input | 1 | Read strobe, advances one item |
| item_o | output | 18 | Current item |
| item_vld_o | output | 1 | Item valid, the cycle after a served read |
| rec_done_o | output | 1 | Pulses with the eighth item of a record |

## Verification
The capture and the read can fall in the same cycle. The tricky case is a capture that lands on the eighth read, when the slot it needs is only freed by that read. The bench drives both strobes together in three states: with the pending slot empty, with it full, and with nothing held at all. It also drives them together in long random traffic. A queue model serves the read first and then tries the capture, and it judges each outcome from the items and done pulses seen at the ports over the following reads.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int ITEM_W    = 18;
    localparam int NUM_ITEMS = 8;
    localparam int IDX_W     = $clog2(NUM_ITEMS);
    localparam int CYC_W     = 15;
    localparam int STAT_W    = 15;
    localparam int REG_W     = 5;
    localparam int EXC_W     = 5;
    localparam int BE_W      = 4;
    localparam int WORD_W    = 32;

    typedef struct packed {
        logic [CYC_W-1:0]  cyc;
        logic [STAT_W-1:0] status;
        logic [REG_W-1:0]  dst_idx;
        logic              dst_wr;
        logic [EXC_W-1:0]  exc_kind;
        logic              exc_taken;
        logic              is_load;
        logic              is_store;
        logic [BE_W-1:0]   byte_en;
        logic [WORD_W-1:0] data_word;
        logic [WORD_W-1:0] addr_word;
        logic [WORD_W-1:0] pc;
    } trace_rec_t;
endpackage

// File: rtl/trs_item_packer.sv
module trs_item_packer
    import trs_pkg::*;
(
    input  trace_rec_t        rec_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ITEM_W-1:0] item_o
);
    logic [ITEM_W-1:0] items [NUM_ITEMS];

    always_comb begin
        items[0] = {rec_i.cyc, rec_i.status[STAT_W-1 -: 3]};
        items[1] = {rec_i.status[STAT_W-4:0], rec_i.dst_idx, rec_i.dst_wr};
        items[2] = {rec_i.exc_kind, rec_i.exc_taken, rec_i.is_load,
                    rec_i.is_store, rec_i.byte_en, rec_i.data_word[31:26]};
        items[3] = rec_i.data_word[25:8];
        items[4] = {rec_i.data_word[7:0], rec_i.addr_word[31:22]};
        items[5] = rec_i.addr_word[21:4];
        items[6] = {rec_i.addr_word[3:0], rec_i.pc[31:18]};
        items[7] = rec_i.pc[17:0];
    end

    assign item_o = items[idx_i];
endmodule

// File: rtl/trs_slot_ctrl.sv
module trs_slot_ctrl
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  trace_rec_t        rec_i,
    input  logic              rd_i,
    input  logic [ITEM_W-1:0] cur_item_i,
    output trace_rec_t        act_rec_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ITEM_W-1:0] item_o,
    output logic              item_vld_o,
    output logic              rec_done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ITEMS - 1);

    typedef struct packed {
        logic              act_vld;
        logic              pend_vld;
        trace_rec_t        act_rec;
        trace_rec_t        pend_rec;
        logic [IDX_W-1:0]  idx;
        logic [ITEM_W-1:0] item;
        logic              item_vld;
        logic              done;
    } state_t;

    state_t st_d, st_q;
    logic   finish;

    always_comb begin
        st_d          = st_q;
        st_d.item_vld = 1'b0;
        st_d.done     = 1'b0;
        finish        = 1'b0;

        if (rd_i) begin
            if (st_q.act_vld) begin
                st_d.item     = cur_item_i;
                st_d.item_vld = 1'b1;
                if (st_q.idx == LAST_IDX) begin
                    st_d.done = 1'b1;
                    st_d.idx  = '0;
                    finish    = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else begin
                st_d.item = '0;
            end
        end

        if (finish) begin
            st_d.act_vld  = st_q.pend_vld;
            st_d.act_rec  = st_q.pend_rec;
            st_d.pend_vld = 1'b0;
        end

        if (cap_i) begin
            if (!st_d.act_vld) begin
                st_d.act_vld = 1'b1;
                st_d.act_rec = rec_i;
            end else if (!st_d.pend_vld) begin
                st_d.pend_vld = 1'b1;
                st_d.pend_rec = rec_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_rec_o  = st_q.act_rec;
    assign idx_o      = st_q.idx;
    assign item_o     = st_q.item;
    assign item_vld_o = st_q.item_vld;
    assign rec_done_o = st_q.done;

    a_r9_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done_o |-> item_vld_o);

    a_r9_done_wraps_index: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done_o |-> (idx_o == '0));

    a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !st_q.act_vld) |=> (!item_vld_o && item_o == '0));

    a_r10_pending_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend_vld |-> st_q.act_vld);

    a_r11_full_capture_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_vld && cap_i && !(rd_i && st_q.idx == LAST_IDX))
        |=> (st_q.pend_vld && $stable(st_q.pend_rec)));

    a_r7_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !item_vld_o);
endmodule

// File: rtl/trace_record_serializer.sv
module trace_record_serializer
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [14:0]       cyc_cnt_i,
    input  logic [14:0]       status_i,
    input  logic [4:0]        dst_idx_i,
    input  logic              dst_wr_i,
    input  logic [4:0]        exc_kind_i,
    input  logic              exc_taken_i,
    input  logic              is_load_i,
    input  logic              is_store_i,
    input  logic [3:0]        byte_en_i,
    input  logic [31:0]       st_data_i,
    input  logic [31:0]       res_data_i,
    input  logic [31:0]       data_addr_i,
    input  logic [31:0]       instr_i,
    input  logic [31:0]       pc_i,
    input  logic              rd_i,
    output logic [17:0]       item_o,
    output logic              item_vld_o,
    output logic              rec_done_o
);
    trace_rec_t        rec_in;
    trace_rec_t        act_rec;
    logic [IDX_W-1:0]  idx;
    logic [ITEM_W-1:0] cur_item;

    always_comb begin
        rec_in.cyc       = cyc_cnt_i;
        rec_in.status    = status_i;
        rec_in.dst_idx   = dst_idx_i;
        rec_in.dst_wr    = dst_wr_i;
        rec_in.exc_kind  = exc_kind_i;
        rec_in.exc_taken = exc_taken_i;
        rec_in.is_load   = is_load_i;
        rec_in.is_store  = is_store_i;
        rec_in.byte_en   = byte_en_i;
        rec_in.data_word = is_store_i ? st_data_i : res_data_i;
        rec_in.addr_word = (is_load_i || is_store_i) ? data_addr_i : instr_i;
        rec_in.pc        = pc_i;
    end

    trs_item_packer u_packer (
        .rec_i  (act_rec),
        .idx_i  (idx),
        .item_o (cur_item)
    );

    trs_slot_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap_i),
        .rec_i      (rec_in),
        .rd_i       (rd_i),
        .cur_item_i (cur_item),
        .act_rec_o  (act_rec),
        .idx_o      (idx),
        .item_o     (item_o),
        .item_vld_o (item_vld_o),
        .rec_done_o (rec_done_o)
    );
endmodule

// File: tb/trace_record_serializer_test.sv
module trace_record_serializer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_i = 1'b0;
    logic [14:0] cyc_cnt_i = '0;
    logic [14:0] status_i = '0;
    logic [4:0]  dst_idx_i = '0;
    logic        dst_wr_i = 1'b0;
    logic [4:0]  exc_kind_i = '0;
    logic        exc_taken_i = 1'b0;
    logic        is_load_i = 1'b0;
    logic        is_store_i = 1'b0;
    logic [3:0]  byte_en_i = '0;
    logic [31:0] st_data_i = '0;
    logic [31:0] res_data_i = '0;
    logic [31:0] data_addr_i = '0;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_i = '0;
    logic        rd_i = 1'b0;
    logic [17:0] item_o;
    logic        item_vld_o;
    logic        rec_done_o;

    trace_record_serializer uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string scen = "R1";

    logic [143:0] recq[$];
    int           exp_idx = 0;
    logic [17:0]  exp_item = '0;
    logic         exp_vld = 1'b0;
    logic         exp_done = 1'b0;
    string        exp_tag = "R1";

    function automatic logic [143:0] flat_now();
        logic [31:0] dw, aw;
        dw = is_store_i ? st_data_i : res_data_i;
        aw = (is_load_i || is_store_i) ? data_addr_i : instr_i;
        return {cyc_cnt_i, status_i, dst_idx_i, dst_wr_i, exc_kind_i, exc_taken_i,
                is_load_i, is_store_i, byte_en_i, dw, aw, pc_i};
    endfunction

    function automatic string tag_of(int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Reference: read served first, then capture placed into a two-deep queue.
    always @(posedge clk) begin
        if (!rst_n) begin
            recq.delete();
            exp_idx = 0; exp_item = '0; exp_vld = 1'b0; exp_done = 1'b0; exp_tag = "R1";
        end else begin
            exp_vld = 1'b0;
            exp_done = 1'b0;
            if (rd_i) begin
                if (recq.size() > 0) begin
                    exp_item = recq[0][143 - 18*exp_idx -: 18];
                    exp_tag  = tag_of(exp_idx);
                    exp_vld  = 1'b1;
                    exp_idx++;
                    if (exp_idx == 8) begin
                        exp_done = 1'b1;
                        exp_idx = 0;
                        void'(recq.pop_front());
                    end
                end else begin
                    exp_item = '0;
                    exp_tag = "R8";
                end
            end else begin
                exp_tag = "R7";
            end
            if (cap_i && recq.size() < 2) recq.push_back(flat_now());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (item_o !== exp_item) begin
                n_bad++;
                $display("FAIL %s [%s] item_o actual=%h expected=%h", exp_tag, scen, item_o, exp_item);
            end
            n_cmp++;
            if (item_vld_o !== exp_vld) begin
                n_bad++;
                $display("FAIL R7 [%s] item_vld_o actual=%b expected=%b", scen, item_vld_o, exp_vld);
            end
            n_cmp++;
            if (rec_done_o !== exp_done) begin
                n_bad++;
                $display("FAIL R9 [%s] rec_done_o actual=%b expected=%b", scen, rec_done_o, exp_done);
            end
        end
    end

    task automatic fields(input int kind);
        cyc_cnt_i   = 15'($urandom);
        status_i    = 15'($urandom);
        dst_idx_i   = 5'($urandom);
        dst_wr_i    = 1'($urandom);
        exc_kind_i  = 5'($urandom);
        exc_taken_i = 1'($urandom);
        byte_en_i   = 4'($urandom);
        st_data_i   = $urandom;
        res_data_i  = $urandom;
        data_addr_i = $urandom;
        instr_i     = $urandom;
        pc_i        = $urandom;
        is_load_i   = (kind == 1);
        is_store_i  = (kind == 2);
        if (kind == 3) begin is_load_i = 1'($urandom); is_store_i = 1'($urandom); end
    endtask

    task automatic tick(input logic rd, input logic cap, input int kind);
        @(negedge clk);
        #1;
        if (cap) fields(kind);
        rd_i = rd;
        cap_i = cap;
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 0);
    endtask

    bit finished = 1'b0;

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog expired");
                wrap_up();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs after reset release
        n_cmp++;
        if (item_o !== '0 || item_vld_o !== 1'b0 || rec_done_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset actual=%h/%b/%b expected=0/0/0", item_o, item_vld_o, rec_done_o);
        end
        rst_n = 1'b1;

        scen = "R8 idle read";
        reads(3);
        scen = "R2-store";
        tick(1'b0, 1'b1, 2); reads(8);
        scen = "R7 gaps load";
        tick(1'b0, 1'b1, 1);
        for (int i = 0; i < 8; i++) begin tick(1'b1, 1'b0, 0); tick(1'b0, 1'b0, 0); tick(1'b0, 1'b0, 0); end
        scen = "R4 non-memory";
        tick(1'b0, 1'b1, 0); reads(8);
        scen = "R10 pending";
        tick(1'b0, 1'b1, 2); reads(3); tick(1'b1, 1'b1, 1);
        scen = "R11 full drop";
        tick(1'b1, 1'b1, 0); tick(1'b0, 1'b1, 3);
        reads(20);
        scen = "R12 final read with capture, pending empty";
        tick(1'b0, 1'b1, 1); reads(7); tick(1'b1, 1'b1, 2); reads(9);
        scen = "R12 final read with capture, pending full";
        tick(1'b0, 1'b1, 0); tick(1'b0, 1'b1, 1); reads(7); tick(1'b1, 1'b1, 2); reads(17);
        scen = "R12 idle read with capture";
        tick(1'b1, 1'b1, 3); reads(9);
        scen = "random";
        for (int i = 0; i < 3000; i++) tick(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 5) == 0), 3);
        tick(1'b0, 1'b0, 0); reads(20); tick(1'b0, 1'b0, 0); tick(1'b0, 1'b0, 0);
        wrap_up();
    end
endmodule